// File: doc/BRIEF.md
# Edge-Latched Read-Only Word Store

This block is a read-only store of 2048 words, each 8 bits wide, read through a strobe-driven interface. It suits a processor bus that multiplexes address and data on the same wires, where the address is only valid for a short time. When the active-low select strobe falls, the block captures the address into an internal register. It ignores the address bus after that until the next select cycle. An active-low output strobe must then fall while the select strobe is low before the word is driven.

The select and output strobes are asynchronous to the block. Each goes through a two-flop synchronizer clocked by the system clock, and falling edges are found from the synchronized levels. The output pins are modelled as an 8-bit data bus and a drive flag that stands in for three-state pins. The drive flag works like a valid flag. There is no ready input and no back-pressure: a driven word stays on the bus for as long as both strobes stay low. The word contents are computed from the address by a function chosen with a parameter, so no preload file is needed. Internally the cells form 128 rows of 128 columns. The upper seven address bits pick the row, and the lower four bits pick one column in each of the eight 16-column groups, one group per output bit.

Top module: `latched_rom`

## Requirements
- R1: Contents: with CONTENT=0 the word at address A is (A mod 256) XOR (A div 256); with CONTENT=1 it is (37*A + 11) mod 256.
- R2: With the select strobe low, once the output strobe has fallen while the select strobe is low, drive_o is 1 and data_o is the word at the latched address.
- R3: The address is captured when a select falling edge is detected. Later changes on addr_i do not change the driven word until the next select falling edge.
- R4: When the select strobe is high, drive_o goes to 0 within three clock edges, whatever the output strobe does.
- R5: data_o reads zero whenever drive_o is 0.
- R6: Raising the output strobe clears drive_o within three clock edges and keeps the latched address: a new output falling edge drives the same word again.
- R7: An output-strobe falling edge seen while the select strobe is high has no effect. If the select strobe later falls while the output strobe is still low, nothing is driven.
- R8: If both strobes fall between the same two rising edges, drive_o is still 0 after the third rising edge and is 1 after the fourth.
- R9: With the output strobe held low, a high pulse on the select strobe of at least three clocks followed by a fall with a new address drives the new word without a new output-strobe edge.
- R10: During and after reset, drive_o is 0 and data_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 11 | Word address, captured when the select strobe falls |
| ce_n_i | input | 1 | Active-low select strobe |
| oe_n_i | input | 1 | Active-low output strobe |
| data_o | output | 8 | Read word, zero when not driven |
| drive_o | output | 1 | Output drive enable (stands in for three-state control) |

## Verification
The assertions assume that each strobe level is held for at least three clock periods. They also assume that the address stays stable from the select falling edge until the edge is detected plus one clock, because the capture happens after synchronization. The bench changes every input just after a falling clock edge and holds the address for at least five clocks after each select fall. It changes the address only after the capture when it checks that the address is ignored. Every address is swept on two instances, one per content function.

// File: rtl/lrom_pkg.sv
package lrom_pkg;

  // Word value stored at address a for content selector mode.
  function automatic logic [31:0] lrom_word(input int mode, input logic [31:0] a);
    logic [31:0] r;
    case (mode)
      1:       r = (a * 32'd37 + 32'd11) & 32'hFF;
      default: r = (a & 32'hFF) ^ ((a >> 8) & 32'hFF);
    endcase
    return r;
  endfunction

  // Single cell value: bit b of the word at address a.
  function automatic logic lrom_bit(input int mode, input logic [31:0] a, input int b);
    return 1'((lrom_word(mode, a) >> b) & 32'd1);
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic level_n,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic              last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe <= '1;
      last <= 1'b1;
    end else begin
      pipe <= {pipe[STAGES-2:0], strobe_n};
      last <= pipe[STAGES-1];
    end
  end

  assign level_n = pipe[STAGES-1];
  assign fall    = last & ~pipe[STAGES-1];
endmodule

// File: rtl/rom_array.sv
module rom_array
  import lrom_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter int COL_W   = 4,
  parameter int CONTENT = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] word
);
  localparam int ROW_W = ADDR_W - COL_W;
  localparam int GROUP = 1 << COL_W;

  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;

  assign row = addr[ADDR_W-1:COL_W];
  assign col = addr[COL_W-1:0];

  // One column group per output bit; the row selects the cells,
  // the low address bits pick one column out of the group.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic [GROUP-1:0] grp;
    always_comb begin
      grp = '0;
      for (int c = 0; c < GROUP; c++) begin
        grp[c] = lrom_bit(CONTENT, (32'(row) << COL_W) | 32'(c), b);
      end
    end
    assign word[b] = grp[col];
  end
endmodule

// File: rtl/read_ctrl.sv
module read_ctrl #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_lvl,
  input  logic              ce_fall,
  input  logic              oe_lvl,
  input  logic              oe_fall,
  output logic [ADDR_W-1:0] addr_lat,
  output logic              pend,
  output logic              rd_ok,
  output logic              armed
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_lat <= '0;
      pend     <= 1'b0;
      rd_ok    <= 1'b0;
    end else if (ce_lvl) begin
      pend  <= 1'b0;
      rd_ok <= 1'b0;
    end else if (ce_fall) begin
      addr_lat <= addr_i;
      pend     <= 1'b1;
      rd_ok    <= 1'b0;
    end else if (pend) begin
      pend  <= 1'b0;
      rd_ok <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                armed <= 1'b0;
    else if (oe_lvl)           armed <= 1'b0;
    else if (oe_fall && !ce_lvl) armed <= 1'b1;
  end
endmodule

// File: rtl/latched_rom.sv
module latched_rom #(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter int COL_W   = 4,
  parameter int SYNC_N  = 2,
  parameter int CONTENT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  output logic [DATA_W-1:0] data_o,
  output logic              drive_o
);
  logic              ce_lvl, ce_fall, oe_lvl, oe_fall;
  logic [ADDR_W-1:0] addr_lat;
  logic              pend, rd_ok, armed;
  logic [DATA_W-1:0] rom_word, data_q;

  strobe_sync #(.STAGES(SYNC_N)) u_ce_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(ce_n_i), .level_n(ce_lvl), .fall(ce_fall)
  );

  strobe_sync #(.STAGES(SYNC_N)) u_oe_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(oe_n_i), .level_n(oe_lvl), .fall(oe_fall)
  );

  read_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .ce_lvl(ce_lvl), .ce_fall(ce_fall), .oe_lvl(oe_lvl), .oe_fall(oe_fall),
    .addr_lat(addr_lat), .pend(pend), .rd_ok(rd_ok), .armed(armed)
  );

  rom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W), .CONTENT(CONTENT)) u_array (
    .addr(addr_lat), .word(rom_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    data_q <= '0;
    else if (pend) data_q <= rom_word;
  end

  assign drive_o = rd_ok & armed & ~ce_lvl & ~oe_lvl;
  assign data_o  = drive_o ? data_q : '0;
endmodule

// File: rtl/latched_rom_chk.sv
module latched_rom_chk
  import lrom_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter int CONTENT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n_i,
  input logic              oe_n_i,
  input logic              ce_fall,
  input logic [ADDR_W-1:0] addr_lat,
  input logic [DATA_W-1:0] data_o,
  input logic              drive_o
);
  // R2 / R1: a driven word equals the content function at the latched address
  a_r2_driven_word: assert property (@(posedge clk) disable iff (!rst_n)
    drive_o |-> data_o == DATA_W'(lrom_word(CONTENT, 32'(addr_lat))));

  // R3: the latched address only moves on a detected select fall
  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_fall |=> $stable(addr_lat));

  // R4: select high for four samples forces the drive off
  a_r4_select_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n_i && $past(ce_n_i, 1) && $past(ce_n_i, 2) && $past(ce_n_i, 3)) |-> !drive_o);

  // R5: undriven bus reads zero
  a_r5_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_o |-> data_o == '0);

  // R6: output strobe high for four samples forces the drive off
  a_r6_output_off: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n_i && $past(oe_n_i, 1) && $past(oe_n_i, 2) && $past(oe_n_i, 3)) |-> !drive_o);
endmodule

bind latched_rom latched_rom_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CONTENT(CONTENT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
  .ce_fall(ce_fall), .addr_lat(addr_lat), .data_o(data_o), .drive_o(drive_o)
);

// File: tb/latched_rom_test.sv
module latched_rom_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addr = '0;
  logic        ce_n = 1'b1;
  logic        oe_n = 1'b1;
  logic [7:0]  d1, d0;
  logic        v1, v0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // uut holds content 1, uut0 content 0; both share all inputs
  latched_rom #(.CONTENT(1)) uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .ce_n_i(ce_n), .oe_n_i(oe_n),
    .data_o(d1), .drive_o(v1)
  );
  latched_rom #(.CONTENT(0)) uut0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .ce_n_i(ce_n), .oe_n_i(oe_n),
    .data_o(d0), .drive_o(v0)
  );

  function automatic int exp1(input int a);
    return (a * 37 + 11) % 256;
  endfunction
  function automatic int exp0(input int a);
    return (a % 256) ^ (a / 256);
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic both_word(input string req, input int a);
    check(req, int'(v1), 1);
    check(req, int'(d1), exp1(a));
    check(req, int'(v0), 1);
    check(req, int'(d0), exp0(a));
  endtask

  task automatic both_idle(input string req);
    check(req, int'(v1), 0);
    check(req, int'(d1), 0);
    check(req, int'(v0), 0);
    check(req, int'(d0), 0);
  endtask

  initial begin
    step(3);
    both_idle("R10 in reset");
    rst_n = 1'b1;
    step(3);
    both_idle("R10 after reset");

    // R1 R2 R3 R4 R5: every address on both content functions
    for (int a = 0; a < 2048; a++) begin
      addr = 11'(a); ce_n = 1'b0; oe_n = 1'b0;
      step(5);
      both_word("R1 R2 sweep", a);
      addr = ~11'(a);
      step(2);
      both_word("R3 address ignored", a);
      ce_n = 1'b1; oe_n = 1'b1;
      step(4);
      if (a % 64 == 0) both_idle("R4 R5 select high");
    end

    // R8: exact latency with both strobes falling together
    addr = 11'd1234; ce_n = 1'b0; oe_n = 1'b0;
    step(3);
    check("R8 not yet driven", int'(v1), 0);
    step(1);
    check("R8 driven at fourth edge", int'(v1), 1);
    check("R8 word", int'(d1), exp1(1234));

    // R6: output strobe off, address kept across re-arm
    oe_n = 1'b1; addr = 11'd7;
    step(4);
    both_idle("R6 output strobe high");
    oe_n = 1'b0;
    step(5);
    both_word("R6 same word after re-arm", 1234);

    // R4: select high while output strobe stays low
    ce_n = 1'b1;
    step(3);
    both_idle("R4 select high with output low");

    // R9: re-latch with output strobe still low
    addr = 11'd2047; ce_n = 1'b0;
    step(5);
    both_word("R9 relatch new address", 2047);

    // R7: output strobe falls while select is high
    ce_n = 1'b1; oe_n = 1'b1;
    step(4);
    oe_n = 1'b0;
    step(4);
    addr = 11'd300; ce_n = 1'b0;
    step(6);
    both_idle("R7 early output fall ignored");
    oe_n = 1'b1;
    step(4);
    oe_n = 1'b0;
    step(5);
    both_word("R7 proper fall drives", 300);

    ce_n = 1'b1; oe_n = 1'b1;
    step(4);
    both_idle("R4 R5 final idle");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule